// File: doc/BRIEF.md
# Receive descriptor chain walker

This block keeps one descriptor pointer per receive priority queue and walks each queue along a singly linked list of receive descriptors that sit in host memory. Software loads a queue's pointer while that queue is idle and then starts it with an enable command that carries a per-queue select mask. Each time the downstream logic reports that the current descriptor has been used up, the queue reads that descriptor's link word through a shared memory-read port. It then either moves its pointer to the next descriptor or, if the link is empty, parks on the last one.

A parked queue keeps its pointer. Any later enable command aimed at it reads the same link word again, so descriptors that software appended to the tail are picked up without reloading the pointer. A small combinational mapper picks the destination queue for an incoming frame from its VLAN priority code point and the number of queues in use.

Each queue runs its own state machine with five states. QS_IDLE goes to QS_READY on an enable with a non-zero pointer. QS_READY goes to QS_FREQ on a consume pulse. QS_FREQ goes to QS_FWAIT when the arbiter accepts its read. QS_FWAIT goes to QS_READY on a non-empty link and to QS_PARK on an empty one. QS_PARK goes back to QS_FREQ on an enable. The shared arbiter runs AS_IDLE, then AS_REQ when it picks a requester, then AS_WAIT on the read handshake, and back to AS_IDLE on the response. A soft reset returns every machine to its idle state.

Top module: `rx_desc_walker`

## Requirements
- R1: After the asynchronous reset and after a synchronous soft reset, every pointer reads 0x00000000, every queue is idle, and no ignored-write flags, stall flags or memory reads are asserted.
- R2: A pointer write to an idle queue stores the written word with bits 2:0 forced to zero. Reading back through the selected read port returns that value.
- R3: A pointer write to a queue that is not idle leaves its pointer unchanged and sets that queue's ignored-write flag. The flag stays set until a soft reset.
- R4: An enable command whose select bit is set moves an idle queue with a non-zero pointer to active. An idle queue with a zero pointer stays idle, and a queue that is already active is not affected.
- R5: A consume pulse for an active queue that holds a descriptor issues one link read at the pointer plus the link offset, which defaults to 0. A consume pulse for an idle or parked queue issues no read.
- R6: When a link read returns a word whose bits 31:3 are not all zero, the pointer becomes that word with bits 2:0 cleared, and the queue again holds a descriptor.
- R7: When a link read returns a word whose bits 31:3 are all zero (NULL), the pointer keeps its value and the queue raises its stall flag.
- R8: An enable command for a parked queue reads the same link word again. A non-NULL result advances the queue as in R6, and a NULL result parks it again.
- R9: At most one link read is outstanding at a time. Queues that request in the same cycle are served lowest index first, and a read request keeps its valid and address unchanged until it is accepted.
- R10: For a tagged frame, the destination queue is PCP >> (3 - n), where n is the queue-count select (0, 1 or 2 for 1, 2 or 4 queues). Larger selects are clamped to log2 of the queue count. An untagged frame goes to queue 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| cfg_we | input | 1 | Pointer write strobe |
| cfg_sel | input | QW | Queue selected for pointer write and read |
| cfg_wdata | input | AW | Pointer write data |
| cfg_rdata | output | AW | Pointer of the selected queue |
| wr_ignored | output | NQ | Sticky flag per queue: a write arrived while the queue was not idle |
| en_vld | input | 1 | Enable command strobe |
| en_sel | input | NQ | Queue select mask for the enable command |
| cons | input | NQ | Per-queue pulse: the current descriptor was consumed |
| q_idle | output | NQ | Queue is idle |
| q_active | output | NQ | Queue holds a descriptor or is fetching a link |
| q_stall | output | NQ | Queue is parked on a NULL link |
| mrd_valid | output | 1 | Link read request valid |
| mrd_ready | input | 1 | Memory accepts the read request |
| mrd_addr | output | AW | Link read address |
| mrsp_valid | input | 1 | Link read response valid |
| mrsp_data | input | AW | Link read response word |
| vlan_tagged | input | 1 | Frame carries a VLAN tag |
| vlan_pcp | input | 3 | VLAN priority code point |
| nq_log2 | input | 2 | log2 of the number of queues in use |
| frm_queue | output | QW | Destination queue for the frame |

## Verification
The assertions assume that memory returns exactly one response for each accepted read, and that it does so only after the handshake. They also assume that a soft reset is not issued while a read is outstanding, because a late response would otherwise reach a reset arbiter. The bench's memory model answers every accepted request exactly once, two cycles after the handshake, and the stimulus only issues a soft reset once every queue has settled. Holding the ready input low for several cycles, with three queues requesting at once, exercises the hold-until-accepted rule and the fixed service order.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

    localparam int ALIGN_BITS = 3;

    typedef enum logic [2:0] {
        QS_IDLE,
        QS_READY,
        QS_FREQ,
        QS_FWAIT,
        QS_PARK
    } q_state_e;

    typedef enum logic [1:0] {
        AS_IDLE,
        AS_REQ,
        AS_WAIT
    } arb_state_e;

endpackage

// File: rtl/rdw_queue.sv
module rdw_queue
    import rdw_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LINK_OFS = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          en_hit,
    input  logic          cons,
    input  logic          fetch_gnt,
    input  logic          rsp_hit,
    input  logic [AW-1:0] rsp_link,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic [AW-1:0] ptr,
    output logic          wr_ign,
    output logic          st_idle,
    output logic          st_active,
    output logic          st_stall,
    output logic          st_wait
);

    localparam logic [ALIGN_BITS-1:0] ZERO_LOW = '0;

    q_state_e state, state_nx;
    logic     link_nz;
    logic     ptr_nz;

    assign link_nz = |rsp_link[AW-1:ALIGN_BITS];
    assign ptr_nz  = |ptr[AW-1:ALIGN_BITS];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= QS_IDLE;
        end else if (soft_rst) begin
            state <= QS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            QS_IDLE:  if (en_hit && ptr_nz) state_nx = QS_READY;
            QS_READY: if (cons)             state_nx = QS_FREQ;
            QS_FREQ:  if (fetch_gnt)        state_nx = QS_FWAIT;
            QS_FWAIT: if (rsp_hit)          state_nx = link_nz ? QS_READY : QS_PARK;
            QS_PARK:  if (en_hit)           state_nx = QS_FREQ;
            default:                        state_nx = QS_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        st_idle   = (state == QS_IDLE);
        st_stall  = (state == QS_PARK);
        st_wait   = (state == QS_FWAIT);
        fetch_req = (state == QS_FREQ);
        st_active = (state == QS_READY) || (state == QS_FREQ) || (state == QS_FWAIT);
    end

    assign fetch_addr = ptr + AW'(LINK_OFS);

    // pointer register and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            wr_ign <= 1'b0;
        end else if (soft_rst) begin
            ptr    <= '0;
            wr_ign <= 1'b0;
        end else begin
            if (wr_en && state == QS_IDLE) begin
                ptr <= {wr_data[AW-1:ALIGN_BITS], ZERO_LOW};
            end else if (state == QS_FWAIT && rsp_hit && link_nz) begin
                ptr <= {rsp_link[AW-1:ALIGN_BITS], ZERO_LOW};
            end
            if (wr_en && state != QS_IDLE) begin
                wr_ign <= 1'b1;
            end
        end
    end

    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == QS_PARK && !soft_rst) |=> $stable(ptr)); // R7

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state != QS_IDLE && !rsp_hit && !soft_rst) |=> ($stable(ptr) && wr_ign)); // R3

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == QS_FWAIT && rsp_hit && link_nz && !soft_rst)
        |=> (ptr[AW-1:ALIGN_BITS] == $past(rsp_link[AW-1:ALIGN_BITS]) && state == QS_READY)); // R6

    AST_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == QS_PARK && en_hit && !soft_rst) |=> (state == QS_FREQ && $stable(ptr))); // R8

    AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == QS_IDLE && !ptr_nz && !soft_rst) |=> (state == QS_IDLE)); // R4

endmodule

// File: rtl/rdw_arb.sv
module rdw_arb
    import rdw_pkg::*;
#(
    parameter int NQ = 4,
    parameter int AW = 32,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic [NQ-1:0]          req,
    input  logic [NQ-1:0][AW-1:0]  addr_vec,
    input  logic                   mrd_ready,
    input  logic                   mrsp_valid,
    output logic                   mrd_valid,
    output logic [AW-1:0]          mrd_addr,
    output logic [NQ-1:0]          gnt,
    output logic [NQ-1:0]          rsp_hit
);

    arb_state_e    state, state_nx;
    logic [QW-1:0] owner;
    logic [QW-1:0] pick_idx;
    logic          pick_any;
    logic [AW-1:0] addr_q;

    // lowest index wins
    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_any = 1'b1;
                pick_idx = QW'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= AS_IDLE;
        end else if (soft_rst) begin
            state <= AS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            AS_IDLE: if (pick_any)   state_nx = AS_REQ;
            AS_REQ:  if (mrd_ready)  state_nx = AS_WAIT;
            AS_WAIT: if (mrsp_valid) state_nx = AS_IDLE;
            default:                 state_nx = AS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner  <= '0;
            addr_q <= '0;
        end else if (state == AS_IDLE && pick_any) begin
            owner  <= pick_idx;
            addr_q <= addr_vec[pick_idx];
        end
    end

    always_comb begin
        mrd_valid = (state == AS_REQ);
        mrd_addr  = addr_q;
        for (int i = 0; i < NQ; i++) begin
            gnt[i]     = (state == AS_REQ)  && mrd_ready  && (owner == QW'(i));
            rsp_hit[i] = (state == AS_WAIT) && mrsp_valid && (owner == QW'(i));
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_valid && !mrd_ready && !soft_rst) |=> (mrd_valid && $stable(mrd_addr))); // R9

    AST_NO_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_valid && mrd_ready && !soft_rst) |=> !mrd_valid); // R9

endmodule

// File: rtl/rdw_prio_map.sv
module rdw_prio_map #(
    parameter int NQ = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int LQ = (NQ > 1) ? $clog2(NQ) : 0
) (
    input  logic          vlan_tagged,
    input  logic [2:0]    vlan_pcp,
    input  logic [1:0]    nq_log2,
    output logic [QW-1:0] frm_queue
);

    localparam logic [1:0] LQ_L = 2'(LQ);

    logic [1:0] eff;
    logic [2:0] shifted;

    always_comb begin
        eff       = (nq_log2 > LQ_L) ? LQ_L : nq_log2;
        shifted   = vlan_pcp >> (2'd3 - eff);
        frm_queue = vlan_tagged ? shifted[QW-1:0] : '0;
    end

endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
    import rdw_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int AW       = 32,
    parameter int LINK_OFS = 0,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          cfg_we,
    input  logic [QW-1:0] cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    output logic [NQ-1:0] wr_ignored,
    input  logic          en_vld,
    input  logic [NQ-1:0] en_sel,
    input  logic [NQ-1:0] cons,
    output logic [NQ-1:0] q_idle,
    output logic [NQ-1:0] q_active,
    output logic [NQ-1:0] q_stall,
    output logic          mrd_valid,
    input  logic          mrd_ready,
    output logic [AW-1:0] mrd_addr,
    input  logic          mrsp_valid,
    input  logic [AW-1:0] mrsp_data,
    input  logic          vlan_tagged,
    input  logic [2:0]    vlan_pcp,
    input  logic [1:0]    nq_log2,
    output logic [QW-1:0] frm_queue
);

    logic [NQ-1:0][AW-1:0] ptr_vec;
    logic [NQ-1:0][AW-1:0] faddr_vec;
    logic [NQ-1:0]         freq_vec;
    logic [NQ-1:0]         gnt_vec;
    logic [NQ-1:0]         rsp_vec;
    logic [NQ-1:0]         wait_vec;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        rdw_queue #(
            .AW       (AW),
            .LINK_OFS (LINK_OFS)
        ) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst   (soft_rst),
            .wr_en      (cfg_we && (cfg_sel == QW'(q))),
            .wr_data    (cfg_wdata),
            .en_hit     (en_vld && en_sel[q]),
            .cons       (cons[q]),
            .fetch_gnt  (gnt_vec[q]),
            .rsp_hit    (rsp_vec[q]),
            .rsp_link   (mrsp_data),
            .fetch_req  (freq_vec[q]),
            .fetch_addr (faddr_vec[q]),
            .ptr        (ptr_vec[q]),
            .wr_ign     (wr_ignored[q]),
            .st_idle    (q_idle[q]),
            .st_active  (q_active[q]),
            .st_stall   (q_stall[q]),
            .st_wait    (wait_vec[q])
        );
    end

    rdw_arb #(
        .NQ (NQ),
        .AW (AW)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .req        (freq_vec),
        .addr_vec   (faddr_vec),
        .mrd_ready  (mrd_ready),
        .mrsp_valid (mrsp_valid),
        .mrd_valid  (mrd_valid),
        .mrd_addr   (mrd_addr),
        .gnt        (gnt_vec),
        .rsp_hit    (rsp_vec)
    );

    rdw_prio_map #(
        .NQ (NQ)
    ) u_map (
        .vlan_tagged (vlan_tagged),
        .vlan_pcp    (vlan_pcp),
        .nq_log2     (nq_log2),
        .frm_queue   (frm_queue)
    );

    assign cfg_rdata = ptr_vec[cfg_sel];

    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wait_vec)); // R9

    AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_idle & q_stall) && ((q_idle & q_active) == '0) && ((q_stall & q_active) == '0)); // R7

    AST_UNTAGGED_Q0: assert property (@(posedge clk) disable iff (!rst_n)
        !vlan_tagged |-> (frm_queue == '0)); // R10

    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (q_idle == '1 && !mrd_valid && wr_ignored == '0)); // R1

endmodule

// File: tb/rx_desc_walker_tb.sv
module rx_desc_walker_tb;

    localparam int NQ = 4;
    localparam int AW = 32;
    localparam int QW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          cfg_we = 1'b0;
    logic [QW-1:0] cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic [NQ-1:0] wr_ignored;
    logic          en_vld = 1'b0;
    logic [NQ-1:0] en_sel = '0;
    logic [NQ-1:0] cons = '0;
    logic [NQ-1:0] q_idle, q_active, q_stall;
    logic          mrd_valid;
    logic          mrd_ready = 1'b1;
    logic [AW-1:0] mrd_addr;
    logic          mrsp_valid = 1'b0;
    logic [AW-1:0] mrsp_data = '0;
    logic          vlan_tagged = 1'b0;
    logic [2:0]    vlan_pcp = '0;
    logic [1:0]    nq_log2 = '0;
    logic [QW-1:0] frm_queue;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] link_tbl [0:127];
    logic [AW-1:0] req_log  [0:63];
    int            req_cnt = 0;
    int            pend = 0;
    logic [AW-1:0] pend_data = '0;

    always #4 clk = ~clk;

    rx_desc_walker u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .wr_ignored(wr_ignored), .en_vld(en_vld), .en_sel(en_sel), .cons(cons),
        .q_idle(q_idle), .q_active(q_active), .q_stall(q_stall),
        .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
        .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
        .vlan_tagged(vlan_tagged), .vlan_pcp(vlan_pcp), .nq_log2(nq_log2),
        .frm_queue(frm_queue)
    );

    // memory model: answer two edges after the handshake
    always @(posedge clk) begin
        mrsp_valid <= 1'b0;
        if (pend > 0) begin
            if (pend == 1) begin
                mrsp_valid <= 1'b1;
                mrsp_data  <= pend_data;
            end
            pend <= pend - 1;
        end
        if (rst_n && mrd_valid && mrd_ready) begin
            req_log[req_cnt[5:0]] <= mrd_addr;
            req_cnt   <= req_cnt + 1;
            pend      <= 2;
            pend_data <= link_tbl[mrd_addr[9:3]];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ptr(input int q, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = QW'(q); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_ptr(input int q, output logic [31:0] d);
        cfg_sel = QW'(q);
        #1;
        d = cfg_rdata;
    endtask

    task automatic enable(input logic [NQ-1:0] m);
        @(negedge clk);
        en_vld = 1'b1; en_sel = m;
        @(negedge clk);
        en_vld = 1'b0; en_sel = '0;
    endtask

    task automatic consume(input logic [NQ-1:0] m);
        @(negedge clk);
        cons = m;
        @(negedge clk);
        cons = '0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic check_cleared(input string tag);
        logic [31:0] v;
        for (int q = 0; q < NQ; q++) begin
            rd_ptr(q, v);
            chk(v == 32'h0, "R1", {tag, " pointer"}, v, 32'h0);
        end
        chk(q_idle == 4'hF, "R1", {tag, " idle"}, 32'(q_idle), 32'hF);
        chk(q_active == 4'h0 && q_stall == 4'h0, "R1", {tag, " active/stall"},
            32'({q_active, q_stall}), 32'h0);
        chk(wr_ignored == 4'h0, "R1", {tag, " ignored flags"}, 32'(wr_ignored), 32'h0);
        chk(mrd_valid == 1'b0, "R1", {tag, " read valid"}, 32'(mrd_valid), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] vals [0:3];
        int base;

        for (int i = 0; i < 128; i++) link_tbl[i] = '0;
        vals[0] = 32'h1234_5677; vals[1] = 32'hFFFF_FFFF;
        vals[2] = 32'h0000_0008; vals[3] = 32'hABCD_EF01;

        settle(3);
        rst_n = 1'b1;
        settle(2);
        check_cleared("hard reset");

        // R2: write/read sweep over queues and patterns
        for (int q = 0; q < NQ; q++) begin
            for (int k = 0; k < 4; k++) begin
                wr_ptr(q, vals[k]);
                rd_ptr(q, v);
                chk(v == (vals[k] & 32'hFFFF_FFF8), "R2", "pointer readback", v, vals[k] & 32'hFFFF_FFF8);
            end
        end

        // R10: exhaustive mapping sweep
        for (int t = 0; t < 2; t++) begin
            for (int n = 0; n < 4; n++) begin
                for (int p = 0; p < 8; p++) begin
                    int ne;
                    int exp_q;
                    vlan_tagged = t[0]; nq_log2 = 2'(n); vlan_pcp = 3'(p);
                    #1;
                    ne = (n > 2) ? 2 : n;
                    exp_q = (t == 1) ? (p >> (3 - ne)) : 0;
                    chk(int'(frm_queue) == exp_q, "R10", "queue map", 32'(frm_queue), 32'(exp_q));
                end
            end
        end

        // R4: zero pointer stays idle
        wr_ptr(0, 32'h0000_0004);
        enable(4'b0001);
        settle(2);
        chk(q_idle[0] == 1'b1, "R4", "zero pointer enable", 32'(q_idle), 32'hF);

        // chain 0x40 -> 0x80 -> 0xC0 -> NULL
        link_tbl[8'h40 >> 3] = 32'h0000_0080;
        link_tbl[8'h80 >> 3] = 32'h0000_00C7;
        link_tbl[8'hC0 >> 3] = 32'h0000_0005;
        wr_ptr(0, 32'h0000_0040);
        enable(4'b0001);
        settle(2);
        chk(q_active[0] == 1'b1, "R4", "enable activates", 32'(q_active), 32'h1);

        base = req_cnt;
        consume(4'b0010);
        settle(8);
        chk(req_cnt == base && q_idle[1] == 1'b1, "R5", "consume on idle queue", 32'(req_cnt), 32'(base));

        consume(4'b0001);
        settle(10);
        chk(req_cnt == base + 1 && req_log[base[5:0]] == 32'h40, "R5", "link read address",
            req_log[base[5:0]], 32'h40);
        rd_ptr(0, v);
        chk(v == 32'h80, "R6", "advance to second", v, 32'h80);

        consume(4'b0001);
        settle(10);
        rd_ptr(0, v);
        chk(v == 32'hC0, "R6", "advance clears low bits", v, 32'hC0);
        chk(q_active[0] == 1'b1 && q_stall[0] == 1'b0, "R6", "holds descriptor", 32'(q_stall), 32'h0);

        consume(4'b0001);
        settle(10);
        rd_ptr(0, v);
        chk(v == 32'hC0, "R7", "pointer held at NULL", v, 32'hC0);
        chk(q_stall[0] == 1'b1 && q_active[0] == 1'b0, "R7", "stall flag", 32'(q_stall), 32'h1);

        base = req_cnt;
        consume(4'b0001);
        settle(8);
        chk(req_cnt == base, "R5", "consume on parked queue", 32'(req_cnt), 32'(base));

        wr_ptr(0, 32'h0000_0500);
        rd_ptr(0, v);
        chk(v == 32'hC0, "R3", "write while parked", v, 32'hC0);
        chk(wr_ignored[0] == 1'b1, "R3", "ignored flag", 32'(wr_ignored), 32'h1);

        enable(4'b0001);
        settle(10);
        chk(req_cnt == base + 1 && req_log[base[5:0]] == 32'hC0, "R8", "refetch same link",
            req_log[base[5:0]], 32'hC0);
        chk(q_stall[0] == 1'b1, "R8", "still NULL reparks", 32'(q_stall), 32'h1);

        link_tbl[8'hC0 >> 3] = 32'h0000_0105;
        enable(4'b0001);
        settle(10);
        rd_ptr(0, v);
        chk(v == 32'h100, "R8", "appended entry picked up", v, 32'h100);
        chk(q_stall[0] == 1'b0 && q_active[0] == 1'b1, "R8", "resumed", 32'(q_stall), 32'h0);
        chk(wr_ignored[0] == 1'b1, "R3", "flag sticky", 32'(wr_ignored), 32'h1);

        pulse_soft();
        settle(1);
        check_cleared("soft reset");

        // R9: three simultaneous requests, ready held low
        link_tbl[12'h100 >> 3] = 32'h0000_01C0;
        link_tbl[12'h140 >> 3] = 32'h0000_0000;
        link_tbl[12'h180 >> 3] = 32'h0000_0200;
        wr_ptr(1, 32'h100);
        wr_ptr(2, 32'h140);
        wr_ptr(3, 32'h180);
        enable(4'b1110);
        settle(2);
        mrd_ready = 1'b0;
        base = req_cnt;
        consume(4'b1110);
        settle(5);
        chk(mrd_valid == 1'b1 && mrd_addr == 32'h100, "R9", "lowest queue first", mrd_addr, 32'h100);
        chk(req_cnt == base, "R9", "no handshake while not ready", 32'(req_cnt), 32'(base));
        mrd_ready = 1'b1;
        settle(25);
        chk(req_cnt == base + 3, "R9", "three reads", 32'(req_cnt), 32'(base + 3));
        chk(req_log[base[5:0]] == 32'h100, "R9", "order first", req_log[base[5:0]], 32'h100);
        chk(req_log[6'(base + 1)] == 32'h140, "R9", "order second", req_log[6'(base + 1)], 32'h140);
        chk(req_log[6'(base + 2)] == 32'h180, "R9", "order third", req_log[6'(base + 2)], 32'h180);
        chk(q_stall == 4'b0100, "R7", "only queue 2 parked", 32'(q_stall), 32'h4);
        rd_ptr(1, v);
        chk(v == 32'h1C0, "R6", "queue 1 advanced", v, 32'h1C0);
        rd_ptr(3, v);
        chk(v == 32'h200, "R6", "queue 3 advanced", v, 32'h200);

        // R4: enable on an active queue has no effect
        base = req_cnt;
        enable(4'b0010);
        settle(8);
        rd_ptr(1, v);
        chk(v == 32'h1C0 && req_cnt == base, "R4", "enable on active queue", v, 32'h1C0);

        settle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule